// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit with HI/LO Result Registers

This block carries out 32-bit integer multiplication and division, each in a signed and an unsigned form, one bit per clock cycle. A caller raises `start` for one cycle with an operation code and two operands. The unit then stays busy for a fixed number of cycles. When it finishes, it writes its results into two dedicated result registers, HI and LO, which are separate from any general register file. The contents of both registers are always visible on two read ports. A processor uses these ports for its move-from-HI and move-from-LO operations.

A multiply produces a 64-bit product. The high word goes to HI and the low word to LO. A divide places the quotient in LO and the remainder in HI. Signed operations work on operand magnitudes and correct the signs at the end. Overflow is never reported. A result that does not fit simply wraps.

The control is a four-state machine. ST_IDLE waits for `start`. ST_RUN performs 32 iterations, either shift-add multiply steps or restoring divide steps. ST_FIX applies the sign correction and writes HI and LO. ST_DONE raises `done` for one cycle. The transitions are:
- ST_IDLE to ST_RUN when `start` arrives.
- ST_RUN to itself until the 32nd step, then ST_RUN to ST_FIX.
- ST_FIX to ST_DONE unconditionally.
- ST_DONE to ST_RUN when a new `start` is present, otherwise ST_DONE to ST_IDLE.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, HI and LO read zero and both `busy` and `done` are low.
- R2: A `start` pulse is accepted on a clock edge where `busy` is low, and `busy` is high from the next cycle. `op` is encoded as 00 signed multiply, 01 unsigned multiply, 10 signed divide and 11 unsigned divide.
- R3: `done` is high for exactly one cycle, 34 cycles after the accepting edge. `busy` is high for the 33 cycles before it and is low while `done` is high.
- R4: Unsigned multiply writes the upper 32 bits of the 64-bit unsigned product to HI and the lower 32 bits to LO.
- R5: Signed multiply treats both operands as two's complement and writes the 64-bit two's-complement product, high word to HI and low word to LO.
- R6: Unsigned divide writes the quotient to LO and the remainder to HI, so that dividend = quotient × divisor + remainder with remainder < divisor.
- R7: Signed divide truncates the quotient toward zero, and the remainder carries the sign of the dividend (or is zero).
- R8: No overflow is signalled. The most negative dividend divided by -1 yields LO = 0x80000000 and HI = 0.
- R9: A `start` raised while `busy` is high is ignored. HI and LO receive the result of the operation already in progress.
- R10: A divide by zero still completes, with `done` arriving on the normal schedule.
- R11: HI and LO hold their values at all times except on the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 2 | Operation code (see R2) |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | High while an operation is running |
| done | output | 1 | One-cycle completion pulse; HI/LO are valid |
| hi_rd | output | 32 | Current HI register contents |
| lo_rd | output | 32 | Current LO register contents |

## Verification
The hardest cases to reach are at the edges of sign handling. Examples are a dividend of 0x80000000 paired with a divisor of -1, whose magnitude result wraps back to the negative limit, and divides where the remainder must become negative. Uniform random 32-bit operands almost never produce these cases, so the bench places them as directed operations. The random mix also masks divisors down to a few bits so that both small quotients and nonzero remainders of either sign occur often. A second `start` is injected in the middle of a run to show that it leaves the result untouched.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    // Operation code; bit 1 selects divide, bit 0 selects unsigned.
    typedef enum logic [1:0] {
        OP_MULT  = 2'b00,
        OP_MULTU = 2'b01,
        OP_DIV   = 2'b10,
        OP_DIVU  = 2'b11
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2,
        ST_DONE = 2'd3
    } md_state_e;

endpackage

// File: rtl/muldiv_prep.sv
// Converts operands to magnitudes and decides which results need negation.
module muldiv_prep #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] mag_a_o,
    output logic [WIDTH-1:0] mag_b_o,
    output logic             neg_main_o,
    output logic             neg_rem_o
);
    logic is_signed;
    logic a_neg;
    logic b_neg;

    always_comb begin
        is_signed  = ~op_i[0];
        a_neg      = is_signed & a_i[WIDTH-1];
        b_neg      = is_signed & b_i[WIDTH-1];
        mag_a_o    = a_neg ? (~a_i + 1'b1) : a_i;
        mag_b_o    = b_neg ? (~b_i + 1'b1) : b_i;
        // product or quotient is negative when exactly one operand is
        neg_main_o = a_neg ^ b_neg;
        // remainder follows the dividend, only meaningful for divide
        neg_rem_o  = a_neg & op_i[1];
    end
endmodule

// File: rtl/muldiv_step.sv
// One iteration of either shift-add multiply or restoring divide.
// Work register layout: upper WIDTH+1 bits partial sum / remainder,
// lower WIDTH bits multiplier / dividend-quotient.
module muldiv_step #(
    parameter int WIDTH = 32
) (
    input  logic [2*WIDTH:0] work_i,
    input  logic [WIDTH-1:0] opnd_i,
    input  logic             is_div_i,
    output logic [2*WIDTH:0] work_o
);
    logic [WIDTH:0] add_sum;
    logic [WIDTH:0] shifted;
    logic [WIDTH:0] trial;
    logic           below;

    always_comb begin
        add_sum = work_i[2*WIDTH:WIDTH]
                + (work_i[0] ? {1'b0, opnd_i} : '0);
        shifted = {work_i[2*WIDTH-1:WIDTH], work_i[WIDTH-1]};
        trial   = shifted - {1'b0, opnd_i};
        below   = trial[WIDTH];
        if (is_div_i) begin
            work_o = {(below ? shifted : trial), work_i[WIDTH-2:0], ~below};
        end else begin
            work_o = {1'b0, add_sum, work_i[WIDTH-1:1]};
        end
    end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] hi_rd,
    output logic [WIDTH-1:0] lo_rd
);
    import muldiv_pkg::*;

    localparam int CNT_W  = $clog2(WIDTH);
    localparam int WORK_W = 2 * WIDTH + 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

    md_state_e         state_q, state_nx;
    logic [CNT_W-1:0]  step_q;
    logic [WORK_W-1:0] work_q, work_nx;
    logic [WIDTH-1:0]  opnd_q;
    md_op_e            op_q;
    logic              neg_main_q, neg_rem_q;
    logic [WIDTH-1:0]  hi_q, lo_q;

    logic [WIDTH-1:0]   mag_a, mag_b;
    logic               neg_main, neg_rem;
    logic               accept;
    logic [2*WIDTH-1:0] prod_fixed;
    logic [WIDTH-1:0]   quot_fixed, rem_fixed;

    muldiv_prep #(.WIDTH(WIDTH)) u_prep (
        .a_i       (src_a),
        .b_i       (src_b),
        .op_i      (op),
        .mag_a_o   (mag_a),
        .mag_b_o   (mag_b),
        .neg_main_o(neg_main),
        .neg_rem_o (neg_rem)
    );

    muldiv_step #(.WIDTH(WIDTH)) u_step (
        .work_i  (work_q),
        .opnd_i  (opnd_q),
        .is_div_i(op_q[1]),
        .work_o  (work_nx)
    );

    assign accept = start & ~busy;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_nx = ST_RUN;
            ST_RUN:  if (step_q == LAST_STEP) state_nx = ST_FIX;
            ST_FIX:  state_nx = ST_DONE;
            ST_DONE: state_nx = accept ? ST_RUN : ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = (state_q == ST_RUN) || (state_q == ST_FIX);
        done = (state_q == ST_DONE);
    end

    // sign correction applied to the finished magnitudes
    always_comb begin
        prod_fixed = neg_main_q ? (~work_q[2*WIDTH-1:0] + 1'b1)
                                : work_q[2*WIDTH-1:0];
        quot_fixed = neg_main_q ? (~work_q[WIDTH-1:0] + 1'b1)
                                : work_q[WIDTH-1:0];
        rem_fixed  = neg_rem_q  ? (~work_q[2*WIDTH-1:WIDTH] + 1'b1)
                                : work_q[2*WIDTH-1:WIDTH];
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q     <= '0;
            work_q     <= '0;
            opnd_q     <= '0;
            op_q       <= OP_MULT;
            neg_main_q <= 1'b0;
            neg_rem_q  <= 1'b0;
            hi_q       <= '0;
            lo_q       <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (accept) begin
                        step_q     <= '0;
                        work_q     <= {{(WIDTH+1){1'b0}}, mag_a};
                        opnd_q     <= mag_b;
                        op_q       <= md_op_e'(op);
                        neg_main_q <= neg_main;
                        neg_rem_q  <= neg_rem;
                    end
                end
                ST_RUN: begin
                    work_q <= work_nx;
                    step_q <= step_q + 1'b1;
                end
                ST_FIX: begin
                    if (op_q[1]) begin
                        hi_q <= rem_fixed;
                        lo_q <= quot_fixed;
                    end else begin
                        hi_q <= prod_fixed[2*WIDTH-1:WIDTH];
                        lo_q <= prod_fixed[WIDTH-1:0];
                    end
                end
            endcase
        end
    end

    assign hi_rd = hi_q;
    assign lo_rd = lo_q;

endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] hi_rd,
    input logic [WIDTH-1:0] lo_rd
);
    localparam int RUN_LEN = WIDTH + 1;
    localparam int RC_W    = $clog2(RUN_LEN + 2);

    logic [RC_W-1:0] run_cnt;

    // counts consecutive busy cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else           run_cnt <= '0;
    end

    // R3: completion pulse lasts one cycle
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: busy and done never overlap
    assert_busy_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R3: done follows exactly RUN_LEN busy cycles
    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == RC_W'(RUN_LEN)));

    // R2: an accepted start makes the unit busy on the next cycle
    assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R11: result registers change only together with done
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_rd != $past(hi_rd)) || (lo_rd != $past(lo_rd))) |-> done);

endmodule

bind muldiv_hilo muldiv_hilo_chk #(.WIDTH(WIDTH)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .busy (busy),
    .done (done),
    .hi_rd(hi_rd),
    .lo_rd(lo_rd)
);

// File: tb/test_muldiv_hilo.sv
`timescale 1ns/1ps
module test_muldiv_hilo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        busy, done;
    logic [31:0] hi_rd, lo_rd;

    int checks = 0;
    int errors = 0;

    muldiv_hilo i_muldiv_hilo (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b), .busy(busy), .done(done),
        .hi_rd(hi_rd), .lo_rd(lo_rd)
    );

    always #10 clk = ~clk;

    function automatic logic [63:0] model(input logic [1:0] o,
                                          input logic [31:0] a,
                                          input logic [31:0] b);
        longint sa, sb, q, r;
        logic [63:0] p;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (o)
            2'b00: begin q = sa * sb; p = q; end
            2'b01: p = {32'b0, a} * {32'b0, b};
            2'b10: begin q = sa / sb; r = sa % sb; p = {r[31:0], q[31:0]}; end
            default: p = {a % b, a / b};
        endcase
        return p;
    endfunction

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // issue one op; optional second start mid-run (b2 operands)
    task automatic run_op(input logic [1:0] o, input logic [31:0] a,
                          input logic [31:0] b, input string req,
                          input bit check_val, input bit inject);
        int lat;
        @(negedge clk);
        start = 1'b1; op = o; src_a = a; src_b = b;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            if (inject && lat == 10) begin
                start = 1'b1; op = ~o; src_a = ~a; src_b = b + 32'd3;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check({req, " latency R3"}, 64'(lat), 64'd34);
        if (check_val) check(req, {hi_rd, lo_rd}, model(o, a, b));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] ra, rb;
        logic [1:0]  ro;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 hilo", {hi_rd, lo_rd}, 64'd0);
        check("R1 busy/done", {62'd0, busy, done}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {62'd0, busy, done}, 64'd0);

        // R2 busy rises the cycle after start
        @(negedge clk);
        start = 1'b1; op = 2'b01; src_a = 32'd7; src_b = 32'd6;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after accept", {63'd0, busy}, 64'd1);
        while (!done) @(negedge clk);
        check("R4 small multu", {hi_rd, lo_rd}, 64'd42);
        @(negedge clk);
        check("R3 done one cycle", {63'd0, done}, 64'd0);

        // directed corners
        run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 max multu", 1, 0);
        run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 -1*-1", 1, 0);
        run_op(2'b00, 32'h8000_0000, 32'h8000_0000, "R5 minneg squared", 1, 0);
        run_op(2'b00, 32'h8000_0000, 32'd3, "R5 neg*pos", 1, 0);
        run_op(2'b11, 32'd100, 32'd7, "R6 divu", 1, 0);
        run_op(2'b11, 32'hFFFF_FFFF, 32'h8000_0000, "R6 divu big", 1, 0);
        run_op(2'b10, -32'sd7, 32'd2, "R7 -7/2", 1, 0);
        run_op(2'b10, 32'd7, -32'sd2, "R7 7/-2", 1, 0);
        run_op(2'b10, -32'sd7, -32'sd2, "R7 -7/-2", 1, 0);
        run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R8 minneg/-1", 1, 0);
        check("R8 wrap value", {hi_rd, lo_rd}, 64'h0000_0000_8000_0000);
        run_op(2'b11, 32'd55, 32'd0, "R10 divu by zero", 0, 0);
        run_op(2'b10, -32'sd55, 32'd0, "R10 div by zero", 0, 0);
        run_op(2'b00, 32'd123456, -32'sd789, "R9 start ignored", 1, 1);
        run_op(2'b11, 32'd1000, 32'd33, "R9 start ignored div", 1, 1);

        // R11 hold while idle
        ra = hi_rd; rb = lo_rd;
        repeat (5) @(negedge clk);
        check("R11 hold", {hi_rd, lo_rd}, {ra, rb});

        // constrained random mix
        for (int i = 0; i < 60; i++) begin
            ro = 2'($urandom);
            ra = $urandom;
            rb = $urandom;
            if (ro[1]) begin
                if (i % 2 == 0) rb = rb & 32'h0000_00FF;
                if (i % 3 == 0) rb = {{28{rb[31]}}, rb[3:0]};
                if (rb == 32'd0) rb = 32'd1;
            end
            run_op(ro, ra, rb, ro[1] ? (ro[0] ? "R6 rand" : "R7 rand")
                                     : (ro[0] ? "R4 rand" : "R5 rand"), 1, 0);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule